// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Stale-Data Timeout

This block buffers bytes arriving from a serial receiver until the host collects them. A receiver write strobe pushes one byte, and a host read strobe pops the oldest byte. The oldest byte is always visible on the data output before it is read. When queueing is switched off, the block shrinks to a single holding register.

Two interrupt outputs tell the host when to come. A fill interrupt is asserted while the number of stored bytes is at or above a host-chosen threshold. A timeout interrupt is asserted when bytes have been sitting below that threshold for several character times with no traffic. This second interrupt makes sure a short burst is still collected. A sticky overrun flag records any byte that was lost because the queue was full.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, `data_rdy`, `trig_irq`, `tout_irq` and `overrun` are all 0.
- R2: With `fifo_on`=1 the queue holds up to DEPTH (16) bytes. `rd_data` shows the oldest unread byte, bytes leave in arrival order, and `data_rdy` is 1 exactly when at least one byte is stored.
- R3: `trig_irq` is 1 while the stored count is at or above the threshold, and it returns to 0 as soon as a read brings the count below it.
- R4: With `fifo_on`=1, `trig_sel` chooses the threshold: code 0 gives 1 byte, code 1 gives 4, code 2 gives 8 and code 3 gives 14.
- R5: A push while the queue is full and no read happens in the same cycle discards the byte and sets `overrun`. `overrun` stays set until the next `rd_en` clears it.
- R6: A push and a read in the same cycle on a non-empty queue leave the count unchanged. At full capacity, such a cycle loses no byte and does not set `overrun`.
- R7: `rd_en` on an empty queue has no effect. A push together with a read on an empty queue stores the byte.
- R8: While the queue is non-empty and below the threshold, `tout_irq` rises after 4 `char_tick` pulses with no accepted push or read. Every accepted push or read restarts that count.
- R9: `tout_irq` returns to 0 in the cycle after any `rd_en`.
- R10: `char_tick` pulses do not raise `tout_irq` while the queue is empty or at or above the threshold.
- R11: With `fifo_on`=0 the block holds a single byte and its threshold is 1, whatever `trig_sel` is. A second push before a read is discarded and sets `overrun`.
- R12: A change of `fifo_on` empties the queue and clears `overrun` and `tout_irq` on the next clock edge. Any push or read in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_data | input | DW | Byte to push |
| rd_en | input | 1 | Host read strobe (pops the oldest byte) |
| fifo_on | input | 1 | 1 = queue mode, 0 = single holding register |
| trig_sel | input | 2 | Threshold code |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | DW | Oldest stored byte |
| data_rdy | output | 1 | At least one byte stored |
| trig_irq | output | 1 | Count at or above threshold |
| tout_irq | output | 1 | Stale-data timeout |
| overrun | output | 1 | Sticky byte-lost flag |

## Verification
The bench builds the block with its defaults: DW=8, DEPTH=16 and TO_TICKS=4. With these values every threshold code, including the 14-byte code, fits inside the queue. A full wrap of both pointers and the overrun case can be reached in a few dozen cycles, and the four-tick timeout boundary can be checked tick by tick. Single holding register mode and the flush on a mode change are exercised with the same defaults.

// File: rtl/rxq_fifo.sv
`timescale 1ns/1ps
module rxq_fifo #(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int TO_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic          char_tick,
  output logic [DW-1:0] rd_data,
  output logic          data_rdy,
  output logic          trig_irq,
  output logic          tout_irq,
  output logic          overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TO_TICKS + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap, thr;
  logic [TW-1:0] tmr;
  logic          mode_q, tout_q, ovr_q;

  wire flush   = fifo_on != mode_q;
  assign cap   = fifo_on ? CW'(DEPTH) : CW'(1);
  wire empty   = cnt == '0;
  wire full    = cnt >= cap;
  wire do_pop  = rd_en && !empty && !flush;
  wire do_push = wr_en && !flush && (!full || do_pop);
  wire drop    = wr_en && !flush && full && !do_pop;

  always_comb begin
    if (!fifo_on) thr = CW'(1);
    else begin
      case (trig_sel)
        2'd0:    thr = CW'(1);
        2'd1:    thr = CW'(4);
        2'd2:    thr = CW'(8);
        default: thr = CW'(14);
      endcase
    end
  end

  wire below    = cnt < thr;
  wire idle     = !do_push && !do_pop;
  wire tick_hit = char_tick && idle && !empty && below && tmr == TW'(TO_TICKS - 1);

  assign rd_data  = mem[rp];
  assign data_rdy = !empty;
  assign trig_irq = !below;
  assign tout_irq = tout_q;
  assign overrun  = ovr_q;

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; tmr <= '0;
      mode_q <= 1'b0; tout_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      mode_q <= fifo_on;
      if (flush) begin
        wp <= '0; rp <= '0; cnt <= '0; tmr <= '0;
        tout_q <= 1'b0; ovr_q <= 1'b0;
      end else begin
        if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
        if (!idle || empty || !below) tmr <= '0;
        else if (char_tick && tmr != TW'(TO_TICKS)) tmr <= tmr + 1'b1;
        if (rd_en) tout_q <= 1'b0;
        else if (tick_hit) tout_q <= 1'b1;
        if (drop) ovr_q <= 1'b1;
        else if (rd_en) ovr_q <= 1'b0;
      end
    end
  end

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  // R6
  both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && do_pop) |=> cnt == $past(cnt));
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && empty && !flush) |=> !data_rdy);
  // R9
  tout_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !tout_irq);
  // R10
  tout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tout_irq && (empty || !below)) |=> !tout_irq);
  // R12
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!data_rdy && !overrun && !tout_irq));
endmodule

// File: tb/rxq_fifo_test.sv
`timescale 1ns/1ps
module rxq_fifo_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, fifo_on = 1, char_tick = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] rd_data;
  logic data_rdy, trig_irq, tout_irq, overrun;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  rxq_fifo uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .fifo_on(fifo_on), .trig_sel(trig_sel), .char_tick(char_tick),
    .rd_data(rd_data), .data_rdy(data_rdy), .trig_irq(trig_irq),
    .tout_irq(tout_irq), .overrun(overrun));

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] d, input logic re, input logic tk);
    @(negedge clk);
    wr_en = we; wr_data = d; rd_en = re; char_tick = tk;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; char_tick = 0;
  endtask

  task automatic push(input logic [7:0] d); cyc(1, d, 0, 0); endtask
  task automatic pop(); cyc(0, 0, 1, 0); endtask
  task automatic tick(); cyc(0, 0, 0, 1); endtask
  task automatic drain();
    for (int i = 0; i < 20 && data_rdy; i++) pop();
  endtask

  task automatic t_reset();
    chk("R1", "data_rdy", data_rdy, 0);
    chk("R1", "trig_irq", trig_irq, 0);
    chk("R1", "tout_irq", tout_irq, 0);
    chk("R1", "overrun", overrun, 0);
  endtask

  task automatic t_order();
    trig_sel = 2;
    for (int i = 0; i < 7; i++) push(8'hA0 + 8'(i));
    chk("R3", "trig at 7 of 8", trig_irq, 0);
    push(8'hA7);
    chk("R3", "trig at 8 of 8", trig_irq, 1);
    chk("R2", "data_rdy", data_rdy, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R2", "order", rd_data, 8'hA0 + i);
      pop();
      if (i == 0) chk("R3", "trig after drop to 7", trig_irq, 0);
    end
    chk("R2", "empty after drain", data_rdy, 0);
  endtask

  task automatic t_levels();
    trig_sel = 0; push(8'h01);
    chk("R4", "code0 at 1", trig_irq, 1);
    drain();
    trig_sel = 1;
    for (int i = 0; i < 3; i++) push(8'h10);
    chk("R4", "code1 at 3", trig_irq, 0);
    push(8'h10);
    chk("R4", "code1 at 4", trig_irq, 1);
    drain();
    trig_sel = 3;
    for (int i = 0; i < 13; i++) push(8'h20);
    chk("R4", "code3 at 13", trig_irq, 0);
    push(8'h20);
    chk("R4", "code3 at 14", trig_irq, 1);
    drain();
  endtask

  task automatic t_full();
    trig_sel = 3;
    for (int i = 0; i < 16; i++) push(8'(i));
    chk("R5", "no overrun at full", overrun, 0);
    push(8'hFF);
    chk("R5", "overrun set", overrun, 1);
    chk("R5", "head kept", rd_data, 0);
    pop();
    chk("R5", "overrun cleared by read", overrun, 0);
    for (int i = 1; i < 16; i++) begin
      chk("R2", "wrap order", rd_data, i);
      pop();
    end
    chk("R5", "dropped byte absent", data_rdy, 0);
  endtask

  task automatic t_both();
    trig_sel = 1;
    for (int i = 0; i < 4; i++) push(8'h30 + 8'(i));
    cyc(1, 8'h34, 1, 0);
    chk("R6", "trig kept (count 4)", trig_irq, 1);
    pop();
    chk("R6", "trig drops (count 3)", trig_irq, 0);
    for (int i = 0; i < 3; i++) pop();
    chk("R6", "empty after 3 pops", data_rdy, 0);
    trig_sel = 3;
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
    cyc(1, 8'h77, 1, 0);
    chk("R6", "no overrun at full", overrun, 0);
    for (int i = 0; i < 15; i++) pop();
    chk("R6", "newest kept", rd_data, 8'h77);
    drain();
  endtask

  task automatic t_empty();
    pop();
    chk("R7", "empty read ignored", data_rdy, 0);
    push(8'h5A);
    chk("R7", "next byte", rd_data, 8'h5A);
    pop();
    cyc(1, 8'h6B, 1, 0);
    chk("R7", "push+read on empty stores", data_rdy, 1);
    chk("R7", "stored value", rd_data, 8'h6B);
    drain();
  endtask

  task automatic t_tout();
    trig_sel = 3;
    push(8'h01); push(8'h02);
    for (int i = 0; i < 3; i++) tick();
    chk("R8", "no timeout after 3 ticks", tout_irq, 0);
    tick();
    chk("R8", "timeout after 4 ticks", tout_irq, 1);
    pop();
    chk("R9", "timeout cleared by read", tout_irq, 0);
    for (int i = 0; i < 3; i++) tick();
    push(8'h03);
    for (int i = 0; i < 3; i++) tick();
    chk("R8", "push restarts timer", tout_irq, 0);
    tick();
    chk("R8", "timeout after restart", tout_irq, 1);
    pop();
    chk("R9", "cleared again", tout_irq, 0);
    drain();
  endtask

  task automatic t_quiet();
    for (int i = 0; i < 6; i++) tick();
    chk("R10", "empty no timeout", tout_irq, 0);
    trig_sel = 0; push(8'h09);
    for (int i = 0; i < 6; i++) tick();
    chk("R10", "at threshold no timeout", tout_irq, 0);
    drain();
  endtask

  task automatic t_mode();
    trig_sel = 0;
    push(8'h01); push(8'h02); push(8'h03);
    @(negedge clk); fifo_on = 0;
    cyc(0, 0, 0, 0);
    chk("R12", "flushed", data_rdy, 0);
    trig_sel = 3;
    push(8'h11);
    chk("R11", "threshold 1", trig_irq, 1);
    push(8'h22);
    chk("R11", "second push overruns", overrun, 1);
    chk("R11", "first byte kept", rd_data, 8'h11);
    pop();
    chk("R11", "single entry", data_rdy, 0);
    push(8'h33);
    cyc(1, 8'h44, 0, 0);
    @(negedge clk); fifo_on = 1;
    cyc(0, 0, 0, 0);
    chk("R12", "flush on enable", data_rdy, 0);
    chk("R12", "overrun cleared", overrun, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk); #1;
    t_reset();
    t_order();
    t_levels();
    t_full();
    t_both();
    t_empty();
    t_tout();
    t_quiet();
    t_mode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule